// File: doc/BRIEF.md
# Debug trigger chain resolver

This block turns raw per-trigger match indications from a processor pipeline into final fire decisions for a bank of hardware debug triggers. The triggers form fixed pairs: trigger 2i and trigger 2i+1 make up pair i. A pair can be chained. When it is, the two triggers act as one compound condition. Each trigger also carries a timing attribute that says whether the resulting trap is taken before the current instruction or after it.

Configuration arrives one trigger at a time through a valid-qualified write port. Each write carries a trigger index plus enable, timing and chain fields. The chain field only counts when the write targets the even member of a pair. Each cycle the pipeline presents a hit vector. One cycle later the block presents a registered fire vector and three summary flags: any trigger fired, trap on the current instruction, trap on the next instruction.

With the default of five pairs, the pair roles are fetch/fetch, store/store, load/load, fetch/store and fetch/load. Two store triggers may not form a compound condition, so the chain request for pair 1 is never honoured. Address and data comparison, and trap sequencing, belong to other blocks.

Top module: `trig_chain_resolver`

## Requirements
- R1: While reset is high and on the first cycle after it, all fire outputs and summary flags are 0. The configuration is cleared to every trigger disabled, timing 0 and every pair unchained.
- R2: A write with `cfg_valid_i` high and `cfg_idx_i` below the trigger count loads that trigger's enable and timing on the clock edge. A hit presented in the very next cycle sees the new values. A write whose index is at or above the trigger count changes nothing.
- R3: For an unchained pair, trigger k fires exactly when its hit bit and its enable are both 1. `fire_o` shows the result for the hit vector of the previous cycle.
- R4: For a chained pair, neither trigger fires unless both are enabled and both report a hit. When they do fire, they fire together.
- R5: For a chained pair whose two timing values differ, neither trigger fires, even when both are enabled and hit.
- R6: The chain bit of pair i is loaded only by a write to trigger 2i, from its `cfg_chain_i` field. Writes to odd-numbered triggers leave every chain bit unchanged.
- R7: The store/store pair (pair 1 by default) never chains. Its triggers always behave as in R3, whatever chain value is written.
- R8: `any_fire_o` is 1 exactly when at least one bit of `fire_o` is 1.
- R9: Timing value 0 means the trap is taken on the current instruction, and timing value 1 means it is taken on the next instruction. `trap_now_o` is 1 when any fired trigger has timing 0. `trap_next_o` is 1 only when something fired and every fired trigger has timing 1, so the current-instruction trap takes priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 4 | Trigger index of the write |
| cfg_enable_i | input | 1 | Enable value for the addressed trigger |
| cfg_timing_i | input | 1 | Timing value (0 current, 1 next instruction) |
| cfg_chain_i | input | 1 | Chain request, used only when the index is even |
| hit_i | input | 10 | Per-trigger match indications from the pipeline |
| fire_o | output | 10 | Registered per-trigger fire decisions |
| any_fire_o | output | 1 | Registered OR of all fire decisions |
| trap_now_o | output | 1 | A fired trigger asks for a trap on the current instruction |
| trap_next_o | output | 1 | All fired triggers ask for a trap on the next instruction |

## Verification
The assertions assume that the hit vector and the write fields are known values on every clock edge after reset. They also assume that a write and a hit in the same cycle are judged against the configuration held before that write. The stimulus drives every input on the falling edge. It never leaves a field undriven, and it checks each result one full cycle after the hit that caused it. It sweeps all 1024 hit vectors under sixteen arithmetic configuration patterns. These patterns mix chained and unchained pairs, matched and mismatched timing, and partial enables. Every write to an odd trigger carries a chain request of 1, which probes R6.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned DEF_PAIRS        = 5;
  localparam int unsigned DEF_NOCHAIN_PAIR = 1;

  typedef enum logic {
    TIME_NOW  = 1'b0,
    TIME_NEXT = 1'b1
  } trig_time_e;
endpackage

// File: rtl/trig_cfg_bank.sv
module trig_cfg_bank #(
  parameter int unsigned NUM_PAIRS    = trig_pkg::DEF_PAIRS,
  parameter int unsigned NOCHAIN_PAIR = trig_pkg::DEF_NOCHAIN_PAIR,
  localparam int unsigned NUM_TRIG    = 2 * NUM_PAIRS,
  localparam int unsigned IDX_W       = $clog2(NUM_TRIG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_valid,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_enable,
  input  logic                wr_timing,
  input  logic                wr_chain,
  output logic [NUM_TRIG-1:0] en_q,
  output logic [NUM_TRIG-1:0] time_q,
  output logic [NUM_PAIRS-1:0] chain_q
);
  logic [NUM_TRIG-1:0] sel;

  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_trig
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(k);
    assign sel[k] = wr_valid && (wr_idx == MY_IDX);

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[k]   <= 1'b0;
        time_q[k] <= trig_pkg::TIME_NOW;
      end else if (sel[k]) begin
        en_q[k]   <= wr_enable;
        time_q[k] <= wr_timing;
      end
    end
  end

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    if (i == NOCHAIN_PAIR) begin : g_fixed
      assign chain_q[i] = 1'b0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          chain_q[i] <= 1'b0;
        end else if (sel[2*i]) begin
          chain_q[i] <= wr_chain;
        end
      end
    end
  end
endmodule

// File: rtl/trig_pair_resolve.sv
module trig_pair_resolve (
  input  logic [1:0] hit,
  input  logic [1:0] en,
  input  logic [1:0] timing,
  input  logic       chained,
  output logic [1:0] fire
);
  logic [1:0] live;
  logic       both;

  always_comb begin
    live = hit & en;
    both = (&live) && (timing[0] == timing[1]);
    if (chained) begin
      fire = {both, both};
    end else begin
      fire = live;
    end
  end
endmodule

// File: rtl/trig_fire_summary.sv
module trig_fire_summary #(
  parameter int unsigned NUM_TRIG = 2 * trig_pkg::DEF_PAIRS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_TRIG-1:0] fire_d,
  input  logic [NUM_TRIG-1:0] time_d,
  output logic [NUM_TRIG-1:0] fire_q,
  output logic                any_q,
  output logic                now_q,
  output logic                next_q
);
  logic any_d;
  logic now_d;
  logic next_d;

  always_comb begin
    any_d  = |fire_d;
    now_d  = |(fire_d & ~time_d);
    next_d = any_d && !now_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fire_q <= '0;
      any_q  <= 1'b0;
      now_q  <= 1'b0;
      next_q <= 1'b0;
    end else begin
      fire_q <= fire_d;
      any_q  <= any_d;
      now_q  <= now_d;
      next_q <= next_d;
    end
  end
endmodule

// File: rtl/trig_chain_resolver.sv
module trig_chain_resolver #(
  parameter int unsigned NUM_PAIRS    = trig_pkg::DEF_PAIRS,
  parameter int unsigned NOCHAIN_PAIR = trig_pkg::DEF_NOCHAIN_PAIR,
  localparam int unsigned NUM_TRIG    = 2 * NUM_PAIRS,
  localparam int unsigned IDX_W       = $clog2(NUM_TRIG)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_valid_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic                cfg_enable_i,
  input  logic                cfg_timing_i,
  input  logic                cfg_chain_i,
  input  logic [NUM_TRIG-1:0] hit_i,
  output logic [NUM_TRIG-1:0] fire_o,
  output logic                any_fire_o,
  output logic                trap_now_o,
  output logic                trap_next_o
);
  logic [NUM_TRIG-1:0]  en_q;
  logic [NUM_TRIG-1:0]  time_q;
  logic [NUM_PAIRS-1:0] chain_q;
  logic [NUM_TRIG-1:0]  fire_d;

  trig_cfg_bank #(
    .NUM_PAIRS   (NUM_PAIRS),
    .NOCHAIN_PAIR(NOCHAIN_PAIR)
  ) u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (cfg_valid_i),
    .wr_idx   (cfg_idx_i),
    .wr_enable(cfg_enable_i),
    .wr_timing(cfg_timing_i),
    .wr_chain (cfg_chain_i),
    .en_q     (en_q),
    .time_q   (time_q),
    .chain_q  (chain_q)
  );

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    trig_pair_resolve u_pair (
      .hit    (hit_i[2*i+1:2*i]),
      .en     (en_q[2*i+1:2*i]),
      .timing (time_q[2*i+1:2*i]),
      .chained(chain_q[i]),
      .fire   (fire_d[2*i+1:2*i])
    );
  end

  trig_fire_summary #(
    .NUM_TRIG(NUM_TRIG)
  ) u_sum (
    .clk   (clk),
    .rst   (rst),
    .fire_d(fire_d),
    .time_d(time_q),
    .fire_q(fire_o),
    .any_q (any_fire_o),
    .now_q (trap_now_o),
    .next_q(trap_next_o)
  );
endmodule

// File: rtl/trig_chain_checker.sv
module trig_chain_checker #(
  parameter int unsigned NUM_PAIRS    = trig_pkg::DEF_PAIRS,
  parameter int unsigned NOCHAIN_PAIR = trig_pkg::DEF_NOCHAIN_PAIR,
  localparam int unsigned NUM_TRIG    = 2 * NUM_PAIRS,
  localparam int unsigned IDX_W       = $clog2(NUM_TRIG)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cfg_valid_i,
  input logic [IDX_W-1:0]     cfg_idx_i,
  input logic                 cfg_enable_i,
  input logic [NUM_TRIG-1:0]  hit_i,
  input logic [NUM_TRIG-1:0]  fire_o,
  input logic                 any_fire_o,
  input logic                 trap_now_o,
  input logic                 trap_next_o,
  input logic [NUM_TRIG-1:0]  en_q,
  input logic [NUM_TRIG-1:0]  time_q,
  input logic [NUM_PAIRS-1:0] chain_q
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fire_o == '0) && (en_q == '0) && !any_fire_o);

  p_cfg_load_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_valid_i) && (int'($past(cfg_idx_i)) < NUM_TRIG))
      |-> en_q[$past(cfg_idx_i)] == $past(cfg_enable_i));

  p_fire_needs_hit_r3: assert property (@(posedge clk) disable iff (rst)
    (fire_o & ~($past(hit_i) & $past(en_q))) == '0);

  p_any_matches_r8: assert property (@(posedge clk) disable iff (rst)
    any_fire_o == (fire_o != '0));

  p_trap_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(trap_now_o && trap_next_o) && (trap_next_o || trap_now_o) == any_fire_o);

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    if (i != NOCHAIN_PAIR) begin : g_chk
      p_pair_together_r4: assert property (@(posedge clk) disable iff (rst)
        $past(chain_q[i]) |-> fire_o[2*i] == fire_o[2*i+1]);

      p_mismatch_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(chain_q[i]) && ($past(time_q[2*i]) != $past(time_q[2*i+1])))
          |-> fire_o[2*i+1:2*i] == 2'b00);
    end
  end
endmodule

bind trig_chain_resolver trig_chain_checker #(
  .NUM_PAIRS   (NUM_PAIRS),
  .NOCHAIN_PAIR(NOCHAIN_PAIR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_valid_i (cfg_valid_i),
  .cfg_idx_i   (cfg_idx_i),
  .cfg_enable_i(cfg_enable_i),
  .hit_i       (hit_i),
  .fire_o      (fire_o),
  .any_fire_o  (any_fire_o),
  .trap_now_o  (trap_now_o),
  .trap_next_o (trap_next_o),
  .en_q        (en_q),
  .time_q      (time_q),
  .chain_q     (chain_q)
);

// File: tb/trig_chain_resolver_test.sv
module trig_chain_resolver_test;
  localparam int NP   = 5;
  localparam int NT   = 2 * NP;
  localparam int NOCH = 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst;
  logic          cfg_valid_i;
  logic [3:0]    cfg_idx_i;
  logic          cfg_enable_i;
  logic          cfg_timing_i;
  logic          cfg_chain_i;
  logic [NT-1:0] hit_i;
  logic [NT-1:0] fire_o;
  logic          any_fire_o;
  logic          trap_now_o;
  logic          trap_next_o;

  int errors = 0;
  int checks = 0;
  bit m_en [NT];
  bit m_tm [NT];
  bit m_ch [NP];

  trig_chain_resolver uut (
    .clk(clk), .rst(rst), .cfg_valid_i(cfg_valid_i), .cfg_idx_i(cfg_idx_i),
    .cfg_enable_i(cfg_enable_i), .cfg_timing_i(cfg_timing_i), .cfg_chain_i(cfg_chain_i),
    .hit_i(hit_i), .fire_o(fire_o), .any_fire_o(any_fire_o),
    .trap_now_o(trap_now_o), .trap_next_o(trap_next_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NT-1:0] exp_fire(input logic [NT-1:0] h);
    logic [NT-1:0] f;
    for (int i = 0; i < NP; i++) begin
      bit l0 = h[2*i] && m_en[2*i];
      bit l1 = h[2*i+1] && m_en[2*i+1];
      bit chained = m_ch[i] && (i != NOCH);
      if (chained) begin
        bit b = l0 && l1 && (m_tm[2*i] == m_tm[2*i+1]);
        f[2*i] = b;
        f[2*i+1] = b;
      end else begin
        f[2*i] = l0;
        f[2*i+1] = l1;
      end
    end
    return f;
  endfunction

  task automatic cfg_write(input int idx, input bit en, input bit tm, input bit ch);
    @(negedge clk);
    cfg_valid_i  = 1'b1;
    cfg_idx_i    = 4'(idx);
    cfg_enable_i = en;
    cfg_timing_i = tm;
    cfg_chain_i  = ch;
    @(negedge clk);
    cfg_valid_i = 1'b0;
    if (idx < NT) begin
      m_en[idx] = en;
      m_tm[idx] = tm;
      if (idx % 2 == 0) m_ch[idx/2] = ch;
    end
  endtask

  task automatic apply_hit(input logic [NT-1:0] h);
    logic [NT-1:0] f;
    bit any_e;
    bit now_e;
    hit_i = h;
    f = exp_fire(h);
    any_e = (f != '0);
    now_e = 1'b0;
    for (int k = 0; k < NT; k++) if (f[k] && !m_tm[k]) now_e = 1'b1;
    @(negedge clk);
    chk("R3 R4 R5 R6 R7 fire vector", 32'(fire_o), 32'(f));
    chk("R8 any fire", 32'(any_fire_o), 32'(any_e));
    chk("R9 trap now", 32'(trap_now_o), 32'(now_e));
    chk("R9 trap next", 32'(trap_next_o), 32'(any_e && !now_e));
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    cfg_valid_i = 1'b0;
    cfg_idx_i = '0;
    cfg_enable_i = 1'b0;
    cfg_timing_i = 1'b0;
    cfg_chain_i = 1'b0;
    hit_i = '1;
    for (int k = 0; k < NT; k++) begin m_en[k] = 0; m_tm[k] = 0; end
    for (int i = 0; i < NP; i++) m_ch[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 fire during reset", 32'(fire_o), 32'h0);
    chk("R1 any during reset", 32'(any_fire_o | trap_now_o | trap_next_o), 32'h0);
    rst = 1'b0;
    // R1: first hits after reset see all triggers disabled
    apply_hit('1);

    // R2: out-of-range index must not enable anything
    cfg_write(15, 1'b1, 1'b0, 1'b1);
    cfg_write(NT, 1'b1, 1'b0, 1'b1);
    apply_hit('1);
    chk("R2 out-of-range write ignored", 32'(fire_o), 32'h0);

    // R2: write takes effect for the hit in the very next cycle
    cfg_write(4, 1'b1, 1'b0, 1'b0);
    apply_hit(NT'(1) << 4);
    chk("R2 next-cycle enable", 32'(fire_o), 32'h10);

    // R6: odd write with chain request leaves pair 0 unchained
    cfg_write(0, 1'b1, 1'b0, 1'b0);
    cfg_write(1, 1'b1, 1'b0, 1'b1);
    apply_hit(NT'(1));
    chk("R6 odd write does not chain", 32'(fire_o), 32'h1);

    // R7: chain request on store/store pair has no effect
    cfg_write(2, 1'b1, 1'b1, 1'b1);
    cfg_write(3, 1'b1, 1'b1, 1'b1);
    apply_hit(NT'(1) << 2);
    chk("R7 store pair stays unchained", 32'(fire_o), 32'h4);

    // sweeps over arithmetic configuration patterns
    for (int p = 0; p < 16; p++) begin
      for (int k = 0; k < NT; k++) begin
        bit en = (p < 4) ? 1'b1 : (((p + k) % 3) != 0);
        bit tm = 1'(((p >> 1) + k * (p & 1)) & 1);
        bit ch = (k % 2 == 1) ? 1'b1 : (((p >> 2) & 1) != 0 ? 1'b1 : 1'(((k / 2) + (p >> 3)) & 1));
        cfg_write(k, en, tm, ch);
      end
      for (int h = 0; h < (1 << NT); h++) apply_hit(NT'(h));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule